// File: doc/BRIEF.md
# Timer Unit Register Decoder

This block is the register front end of a timer unit holding two or three timer channels. It sits behind one byte-addressed window of 0x30 bytes on a simple bus that completes every read and write in one cycle, with 32-bit data. The block itself holds two registers: a one-bit output-control register and a start register. Every other mapped access is passed, with the offset rebased to the channel's own window, to one of the channels, which sit outside this block.

The start register bits drive each channel's run input. The channels handle counting, reload and capture. They report back with read data and one interrupt line each, and the decoder passes these straight to its outputs. The parameter `THREE_CH` decides whether the third channel exists. The parameter `HAS_OUTCTL` decides whether the output-control register exists. Accesses to resources that are absent are reported on an error output at access time.

Top module: `timer_unit_decoder`

## Requirements
- R1: After reset the start register and the output-control register read as zero, `chan_run` is 3'b000 and `out_ctl` is 0.
- R2: With `HAS_OUTCTL`=1, a write to offset 0x00 stores bit 0 of the data. A read of 0x00 returns that bit in bit 0 with zeros above it, and `out_ctl` shows the stored bit from the cycle after the write.
- R3: With `HAS_OUTCTL`=0, an access to offset 0x00 raises `bus_err`, a read there returns zero, and `out_ctl` stays 0.
- R4: A write to offset 0x04 stores all 32 bits, and a read of 0x04 returns them. From the next cycle `chan_run[i]` equals stored bit i (i = 0, 1, 2). A start write asserts no channel strobe, so stopping and restarting a channel does not reload it.
- R5: Offsets 0x08 to 0x13 go to channel 0. `chan_rd[0]` or `chan_wr[0]` is asserted, `chan_off` is the offset minus 0x08, and a read returns `chan_rdata0`.
- R6: Offsets 0x14 to 0x1F go to channel 1. The offset is rebased by 0x14, and a read returns `chan_rdata1`.
- R7: With `THREE_CH`=1, offsets 0x20 to 0x2F go to channel 2. The offset is rebased by 0x20, and a read returns `chan_rdata2`.
- R8: With `THREE_CH`=0, an access at 0x20 or above raises `bus_err` and asserts no strobe. A start write with bit 2 set raises `bus_err`, but the full value is still stored and read back. `chan_run[2]` stays 0.
- R9: Offsets 0x01 to 0x03, 0x05 to 0x07 and 0x30 to 0x3F are unmapped. A read or write there raises `bus_err` in the same cycle and asserts no strobe. A read there returns zero, and a write changes no register.
- R10: `chan_capt` is 3'b100 when `THREE_CH`=1 and 3'b000 otherwise. Only channel 2 has the capture option.
- R11: `irq_out[i]` equals `chan_irq[i]` in the same cycle. `irq_out[2]` is held at 0 when `THREE_CH`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte offset in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access error, same cycle |
| chan_wr | output | 3 | Per-channel write strobe |
| chan_rd | output | 3 | Per-channel read strobe |
| chan_off | output | 6 | Offset rebased to the channel window |
| chan_wdata | output | 32 | Write data to channels |
| chan_rdata0 | input | 32 | Read data from channel 0 |
| chan_rdata1 | input | 32 | Read data from channel 1 |
| chan_rdata2 | input | 32 | Read data from channel 2 |
| chan_run | output | 3 | Per-channel run enable |
| chan_capt | output | 3 | Per-channel capture option |
| chan_irq | input | 3 | Interrupt from each channel |
| irq_out | output | 3 | Interrupt outputs |
| out_ctl | output | 1 | Output-control bit |

## Verification
The bench sweeps every offset of the 64-byte address space for both reads and writes. It does this on a full configuration and on a configuration with two channels and no output-control register. This catches window edges placed off by one, such as 0x13/0x14 or 0x1F/0x20, which would send a boundary access to the wrong channel or rebase it wrongly. It also catches a decoder that lets the missing third channel answer, which would strobe a channel that does not exist instead of raising the error. Start writes with bit 2 set show whether the two-channel build drops the stored value or drives a phantom run enable. Interrupt and output-control sweeps expose masks that are missing or misplaced.

// File: rtl/timer_unit_decoder.sv
module timer_unit_decoder #(
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter int DW         = 32,
  parameter int AW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic [2:0]    chan_wr,
  output logic [2:0]    chan_rd,
  output logic [AW-1:0] chan_off,
  output logic [DW-1:0] chan_wdata,
  input  logic [DW-1:0] chan_rdata0,
  input  logic [DW-1:0] chan_rdata1,
  input  logic [DW-1:0] chan_rdata2,
  output logic [2:0]    chan_run,
  output logic [2:0]    chan_capt,
  input  logic [2:0]    chan_irq,
  output logic [2:0]    irq_out,
  output logic          out_ctl
);
  localparam logic [AW-1:0] CTL_OFF   = AW'(8'h00);
  localparam logic [AW-1:0] START_OFF = AW'(8'h04);
  localparam logic [AW-1:0] C0_BASE   = AW'(8'h08);
  localparam logic [AW-1:0] C1_BASE   = AW'(8'h14);
  localparam logic [AW-1:0] C2_BASE   = AW'(8'h20);
  localparam logic [AW-1:0] WIN_END   = AW'(8'h30);

  logic          hit_ctl, hit_start, hit_c0, hit_c1, hit_c2, miss, bad_start;
  logic [DW-1:0] start_q;
  logic          ctl_q;

  assign hit_ctl   = HAS_OUTCTL && (bus_addr == CTL_OFF);
  assign hit_start = (bus_addr == START_OFF);
  assign hit_c0    = (bus_addr >= C0_BASE) && (bus_addr < C1_BASE);
  assign hit_c1    = (bus_addr >= C1_BASE) && (bus_addr < C2_BASE);
  assign hit_c2    = THREE_CH && (bus_addr >= C2_BASE) && (bus_addr < WIN_END);
  assign miss      = !(hit_ctl || hit_start || hit_c0 || hit_c1 || hit_c2);
  assign bad_start = !THREE_CH && hit_start && bus_wr && bus_wdata[2];

  assign bus_err    = ((bus_wr || bus_rd) && miss) || bad_start;
  assign chan_wr    = {hit_c2, hit_c1, hit_c0} & {3{bus_wr}};
  assign chan_rd    = {hit_c2, hit_c1, hit_c0} & {3{bus_rd}};
  assign chan_wdata = bus_wdata;

  always_comb begin
    chan_off = '0;
    if (hit_c0) chan_off = bus_addr - C0_BASE;
    else if (hit_c1) chan_off = bus_addr - C1_BASE;
    else if (hit_c2) chan_off = bus_addr - C2_BASE;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctl) bus_rdata = DW'(ctl_q);
      else if (hit_start) bus_rdata = start_q;
      else if (hit_c0) bus_rdata = chan_rdata0;
      else if (hit_c1) bus_rdata = chan_rdata1;
      else if (hit_c2) bus_rdata = chan_rdata2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      ctl_q   <= 1'b0;
    end else if (bus_wr) begin
      if (hit_start) start_q <= bus_wdata;
      if (hit_ctl) ctl_q <= bus_wdata[0];
    end
  end

  assign chan_run  = {start_q[2] & THREE_CH, start_q[1:0]};
  assign chan_capt = {THREE_CH, 2'b00};
  assign irq_out   = {chan_irq[2] & THREE_CH, chan_irq[1:0]};
  assign out_ctl   = ctl_q;
endmodule

module timer_unit_decoder_chk #(
  parameter bit THREE_CH = 1'b1,
  parameter int AW       = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [AW-1:0] bus_addr,
  input logic [31:0]   bus_wdata,
  input logic          bus_err,
  input logic [2:0]    chan_wr,
  input logic [2:0]    chan_rd,
  input logic [AW-1:0] chan_off,
  input logic [2:0]    chan_run,
  input logic [2:0]    irq_out,
  input logic          out_ctl
);
  // R4
  start_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(4)) |=> chan_run[1:0] == $past(bus_wdata[1:0]));
  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(4)) |=> $stable(chan_run));
  // R2
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == AW'(0)) |=> $stable(out_ctl));
  // R5
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_wr) && $onehot0(chan_rd));
  // R9
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (chan_wr == 3'b000 && chan_rd == 3'b000));
  // R6
  off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr[1:0] != 2'b00 || chan_rd[1:0] != 2'b00) |-> chan_off < AW'(12));
  // R8
  no_third_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !THREE_CH |-> (chan_run[2] == 1'b0 && irq_out[2] == 1'b0 && chan_wr[2] == 1'b0));
endmodule

bind timer_unit_decoder timer_unit_decoder_chk #(.THREE_CH(THREE_CH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata[31:0]), .bus_err(bus_err), .chan_wr(chan_wr),
  .chan_rd(chan_rd), .chan_off(chan_off), .chan_run(chan_run),
  .irq_out(irq_out), .out_ctl(out_ctl)
);

// File: tb/tb_timer_unit_decoder.sv
`timescale 1ns/1ps
module tb_timer_unit_decoder;
  logic clk = 0, rst_n = 0, bus_wr = 0, bus_rd = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd0 = 32'h1111_0000, rd1 = 32'h2222_0000, rd2 = 32'h3333_0000;
  logic [2:0] irq_in = '0;
  logic [31:0] a_rdata, b_rdata, a_wd, b_wd;
  logic a_err, b_err, a_ctl, b_ctl;
  logic [2:0] a_wr, a_rd, b_wr, b_rd, a_run, b_run, a_capt, b_capt, a_irq, b_irq;
  logic [5:0] a_off, b_off;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  timer_unit_decoder #(.THREE_CH(1'b1), .HAS_OUTCTL(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(a_rdata), .bus_err(a_err), .chan_wr(a_wr),
    .chan_rd(a_rd), .chan_off(a_off), .chan_wdata(a_wd), .chan_rdata0(rd0),
    .chan_rdata1(rd1), .chan_rdata2(rd2), .chan_run(a_run), .chan_capt(a_capt),
    .chan_irq(irq_in), .irq_out(a_irq), .out_ctl(a_ctl));

  timer_unit_decoder #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(b_rdata), .bus_err(b_err), .chan_wr(b_wr),
    .chan_rd(b_rd), .chan_off(b_off), .chan_wdata(b_wd), .chan_rdata0(rd0),
    .chan_rdata1(rd1), .chan_rdata2(rd2), .chan_run(b_run), .chan_capt(b_capt),
    .chan_irq(irq_in), .irq_out(b_irq), .out_ctl(b_ctl));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected decode, computed from the window map
  task automatic expect_dec(input int a, input bit three, input bit has_ctl,
                            output int ch, output int off, output bit mapped);
    ch = -1; off = 0;
    mapped = (a == 4) || (a == 0 && has_ctl);
    if (a >= 8 && a < 20) begin ch = 0; off = a - 8; end
    else if (a >= 20 && a < 32) begin ch = 1; off = a - 20; end
    else if (a >= 32 && a < 48 && three) begin ch = 2; off = a - 32; end
    if (ch >= 0) mapped = 1;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d,
                          output logic ea, output logic eb);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    #1 ea = a_err; eb = b_err;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic do_read(input logic [5:0] a, output logic [31:0] ra, output logic [31:0] rb,
                         output logic ea, output logic eb);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 ra = a_rdata; rb = b_rdata; ea = a_err; eb = b_err;
    @(negedge clk); bus_rd = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ra, rb; logic ea, eb;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 run a", 32'(a_run), 0); chk("R1 run b", 32'(b_run), 0);
    chk("R1 ctl", 32'(a_ctl), 0);
    do_read(6'h04, ra, rb, ea, eb);
    chk("R1 start a", ra, 0); chk("R1 start b", rb, 0);
    do_read(6'h00, ra, rb, ea, eb);
    chk("R1 ctl read", ra, 0);

    // R5 R6 R7 R8 R9 read sweep over all offsets
    for (int a = 0; a < 64; a++) begin
      int ch, off; bit mp; logic [31:0] e;
      @(negedge clk); bus_rd = 1; bus_addr = 6'(a);
      #1;
      expect_dec(a, 1'b1, 1'b1, ch, off, mp);
      e = (ch == 0) ? rd0 : (ch == 1) ? rd1 : (ch == 2) ? rd2 : 32'h0;
      chk("R5/R6/R7/R9 rdata a", a_rdata, e);
      chk("R9 err a", 32'(a_err), 32'(!mp));
      chk("R5/R6/R7 rd strobe a", 32'(a_rd), (ch >= 0) ? (32'd1 << ch) : 0);
      chk("R5/R6/R7 off a", 32'(a_off), 32'(off));
      chk("R9 no wr a", 32'(a_wr), 0);
      expect_dec(a, 1'b0, 1'b0, ch, off, mp);
      e = (ch == 0) ? rd0 : (ch == 1) ? rd1 : 32'h0;
      chk("R8/R3 rdata b", b_rdata, e);
      chk("R8/R3 err b", 32'(b_err), 32'(!mp));
      chk("R8 rd strobe b", 32'(b_rd), (ch >= 0) ? (32'd1 << ch) : 0);
      chk("R6 off b", 32'(b_off), 32'(off));
      @(negedge clk); bus_rd = 0;
    end

    // R9 write sweep with zero data
    for (int a = 0; a < 64; a++) begin
      int ch, off; bit mp;
      @(negedge clk); bus_wr = 1; bus_addr = 6'(a); bus_wdata = 0;
      #1;
      expect_dec(a, 1'b1, 1'b1, ch, off, mp);
      chk("R9 wr err a", 32'(a_err), 32'(!mp));
      chk("R5/R7 wr strobe a", 32'(a_wr), (ch >= 0) ? (32'd1 << ch) : 0);
      chk("R5/R7 wr off a", 32'(a_off), 32'(off));
      chk("R5 wdata", a_wd, 0);
      expect_dec(a, 1'b0, 1'b0, ch, off, mp);
      chk("R8 wr err b", 32'(b_err), 32'(!mp));
      chk("R8 wr strobe b", 32'(b_wr), (ch >= 0) ? (32'd1 << ch) : 0);
      @(negedge clk); bus_wr = 0;
    end

    // R9 unmapped writes with nonzero data change nothing
    do_write(6'h05, 32'hFFFF_FFFF, ea, eb);
    do_write(6'h31, 32'hFFFF_FFFF, ea, eb);
    chk("R9 err unmapped wr", 32'(ea), 1);
    do_read(6'h04, ra, rb, ea, eb);
    chk("R9 start untouched", ra, 0);
    chk("R9 run untouched", 32'(a_run), 0);
    chk("R9 ctl untouched", 32'(a_ctl), 0);

    // R2 R3 output-control
    do_write(6'h00, 32'hFFFF_FFFF, ea, eb);
    chk("R2 no err", 32'(ea), 0); chk("R3 err", 32'(eb), 1);
    chk("R2 out_ctl", 32'(a_ctl), 1); chk("R3 out_ctl", 32'(b_ctl), 0);
    do_read(6'h00, ra, rb, ea, eb);
    chk("R2 read", ra, 1); chk("R3 read", rb, 0); chk("R3 read err", 32'(eb), 1);
    do_write(6'h00, 32'hFFFF_FFFE, ea, eb);
    chk("R2 clear", 32'(a_ctl), 0);

    // R4 R8 start register
    @(negedge clk); bus_wr = 1; bus_addr = 6'h04; bus_wdata = 32'hDEAD_BEE5;
    #1;
    chk("R4 no strobe a", 32'(a_wr), 0);
    chk("R4 no err a", 32'(a_err), 0);
    chk("R8 bit2 err b", 32'(b_err), 1);
    chk("R4 run before edge", 32'(a_run), 0);
    @(negedge clk); bus_wr = 0;
    chk("R4 run a", 32'(a_run), 3'b101);
    chk("R8 run b", 32'(b_run), 3'b001);
    do_read(6'h04, ra, rb, ea, eb);
    chk("R4 read a", ra, 32'hDEAD_BEE5);
    chk("R8 read b", rb, 32'hDEAD_BEE5);
    do_write(6'h04, 32'h0000_0002, ea, eb);
    chk("R4 run swap a", 32'(a_run), 3'b010);
    chk("R4 run swap b", 32'(b_run), 3'b010);
    chk("R8 no err b", 32'(eb), 0);
    do_write(6'h04, 32'h0000_0000, ea, eb);
    chk("R4 stop", 32'(a_run), 0);

    // R10 R11
    chk("R10 capt a", 32'(a_capt), 3'b100);
    chk("R10 capt b", 32'(b_capt), 3'b000);
    for (int v = 0; v < 8; v++) begin
      @(negedge clk); irq_in = 3'(v);
      #1;
      chk("R11 irq a", 32'(a_irq), 32'(v));
      chk("R11 irq b", 32'(b_irq), 32'(v & 3));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule